// File: doc/BRIEF.md
# Compressed Image Directory Allocator

This block keeps track of where compressed images live in a byte-addressed memory. The lowest `N_SLOTS x 4` bytes of that memory are set aside for a directory. Each directory slot holds a 16-bit start address and a 16-bit byte count. Image data is packed upward from the first byte past the directory. A bump pointer marks the next free byte, and a slot counter marks the next unused directory slot. Nothing is ever freed one image at a time.

When a producer has finished compressing an image, it raises a store request carrying the compressed length. One cycle later the block answers in one of two ways:

- It acknowledges the request, returns the start address to write to, records the start address and length in the next slot, and moves the pointer past the image.
- It raises a full flag and changes nothing.

Once the archive has been drained, for example after an upload, a clear request empties the directory. A separate lookup port reads any slot by index, so a reader can walk the stored images. The memory data path itself lies outside this block.

Top module: `img_dir_alloc`

## Requirements
- R1: After reset the directory holds no images. Every slot reads back address 0 and length 0, and the first accepted store is placed at address `N_SLOTS*4` (32 with the default of 8 slots).
- R2: A store request that is accepted produces a one-cycle `put_ack` pulse in the cycle after the request. In that same cycle, `put_base` carries the value the free pointer held when the request was made.
- R3: Each accepted store advances the free pointer by its length. The next accepted image therefore starts at the previous start address plus the previous length.
- R4: Slots are filled in acceptance order, starting at index 0. A lookup returns the stored start address on `look_base` and the stored length on `look_len`, one cycle after `look_idx` is sampled.
- R5: A store request made while `N_SLOTS` images are held is rejected. The block gives a one-cycle `put_full` pulse with no `put_ack`, and leaves the directory, the slot counter and the free pointer unchanged.
- R6: A store request for which free pointer plus length would exceed `MEM_BYTES` is rejected in the same way as in R5. A store that ends exactly at `MEM_BYTES` is accepted.
- R7: A clear request zeroes every slot, empties the slot counter and returns the free pointer to `N_SLOTS*4`, all effective from the next cycle.
- R8: When a clear request and a store request arrive in the same cycle, the clear takes effect and the store is dropped. Neither `put_ack` nor `put_full` is raised for it.
- R9: A lookup of the slot that a store is filling in that same cycle returns the slot's previous contents. The new contents are visible from the next lookup onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_req | input | 1 | Empty the directory and rewind the free pointer |
| put_req | input | 1 | Request space for one image |
| put_len | input | 16 | Compressed image length in bytes |
| put_ack | output | 1 | Store accepted (one-cycle pulse) |
| put_full | output | 1 | Store rejected (one-cycle pulse) |
| put_base | output | 16 | Start address granted to the last accepted store |
| look_idx | input | 3 | Directory slot to read |
| look_base | output | 16 | Start address held in the selected slot |
| look_len | output | 16 | Length held in the selected slot |

## Verification
Two pairs of functions can fall in the same cycle.

- **Store and clear.** The bench raises both requests on one clock edge. It then expects silence on both store response flags, and the next store must land at `N_SLOTS*4` in slot 0.
- **Store and lookup of the slot being written.** The bench reads the slot that an in-flight store is filling. It expects zeros in that cycle and the new start address and length on the following read.

The capacity and memory-size rejections are judged by the next accepted store. That store must still receive the unchanged free pointer and the unchanged slot index.

// File: rtl/img_dir_alloc.sv
module img_dir_alloc #(
  parameter int N_SLOTS     = 8,
  parameter int AW          = 16,
  parameter int MEM_BYTES   = 4096,
  parameter int ENTRY_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_req,
  input  logic                       put_req,
  input  logic [AW-1:0]              put_len,
  output logic                       put_ack,
  output logic                       put_full,
  output logic [AW-1:0]              put_base,
  input  logic [$clog2(N_SLOTS)-1:0] look_idx,
  output logic [AW-1:0]              look_base,
  output logic [AW-1:0]              look_len
);
  localparam int IW = $clog2(N_SLOTS);
  localparam int CW = $clog2(N_SLOTS + 1);
  localparam logic [AW-1:0] BASE     = AW'(N_SLOTS * ENTRY_BYTES);
  localparam logic [AW:0]   MEM_TOP  = (AW+1)'(MEM_BYTES);
  localparam logic [CW-1:0] SLOT_MAX = CW'(N_SLOTS);

  logic [AW-1:0] free_ptr;
  logic [CW-1:0] used;
  logic [AW-1:0] dir_a [N_SLOTS];
  logic [AW-1:0] dir_l [N_SLOTS];

  wire [AW:0] next_end = {1'b0, free_ptr} + {1'b0, put_len};
  wire        room     = (used < SLOT_MAX) && (next_end <= MEM_TOP);
  wire        live     = put_req && !clr_req;
  wire        take     = live && room;
  wire        deny     = live && !room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_ptr <= BASE;
      used     <= '0;
      put_ack  <= 1'b0;
      put_full <= 1'b0;
      put_base <= '0;
    end else begin
      put_ack  <= take;
      put_full <= deny;
      if (clr_req) begin
        free_ptr <= BASE;
        used     <= '0;
      end else if (take) begin
        free_ptr <= next_end[AW-1:0];
        used     <= used + 1'b1;
        put_base <= free_ptr;
      end
    end
  end

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_a[g] <= '0;
        dir_l[g] <= '0;
      end else if (clr_req) begin
        dir_a[g] <= '0;
        dir_l[g] <= '0;
      end else if (take && used == CW'(g)) begin
        dir_a[g] <= free_ptr;
        dir_l[g] <= put_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      look_base <= '0;
      look_len  <= '0;
    end else begin
      look_base <= dir_a[look_idx];
      look_len  <= dir_l[look_idx];
    end
  end

  // R2
  ack_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(put_ack && put_full));

  // R2
  grant_in_heap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    put_ack |-> (put_base >= BASE) && ({1'b0, put_base} < MEM_TOP));

  // R5
  deny_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    put_full |-> $stable(free_ptr) && $stable(used));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= SLOT_MAX);

  // R7
  clear_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (used == '0) && (free_ptr == BASE));

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && put_req) |=> !put_ack && !put_full);

  // R3
  ptr_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !put_ack) |=> free_ptr >= $past(free_ptr));
endmodule

// File: tb/img_dir_alloc_test.sv
module img_dir_alloc_test;
  localparam int N = 8;
  localparam int MEM = 4096;
  localparam int BASE = N * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_req = 1'b0, put_req = 1'b0;
  logic [15:0] put_len = '0;
  logic put_ack, put_full;
  logic [15:0] put_base, look_base, look_len;
  logic [2:0] look_idx = '0;

  int total = 0, bad = 0;
  int exp_free;
  int exp_cnt;
  int slot_a [N];
  int slot_l [N];

  always #2 clk = ~clk;

  img_dir_alloc #(.N_SLOTS(N), .AW(16), .MEM_BYTES(MEM), .ENTRY_BYTES(4)) uut (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .put_req(put_req),
    .put_len(put_len), .put_ack(put_ack), .put_full(put_full),
    .put_base(put_base), .look_idx(look_idx), .look_base(look_base),
    .look_len(look_len));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    exp_free = BASE;
    exp_cnt = 0;
    for (int i = 0; i < N; i++) begin
      slot_a[i] = 0;
      slot_l[i] = 0;
    end
  endtask

  task automatic store(input int len, input string req);
    bit fits;
    fits = (exp_cnt < N) && (exp_free + len <= MEM);
    @(negedge clk);
    put_req = 1'b1;
    put_len = 16'(len);
    @(negedge clk);
    put_req = 1'b0;
    check({req, " ack"}, int'(put_ack), int'(fits));
    check({req, " full"}, int'(put_full), int'(!fits));
    if (fits) begin
      check({req, " base"}, int'(put_base), exp_free);
      slot_a[exp_cnt] = exp_free;
      slot_l[exp_cnt] = len;
      exp_cnt++;
      exp_free += len;
    end
  endtask

  task automatic look_all(input string req);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      look_idx = 3'(i);
      @(negedge clk);
      check({req, " look_base"}, int'(look_base), slot_a[i]);
      check({req, " look_len"}, int'(look_len), slot_l[i]);
    end
  endtask

  task automatic clear();
    @(negedge clk);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    model_clear();
  endtask

  task automatic t_reset();
    model_clear();
    check("R1 ack idle", int'(put_ack), 0);
    check("R1 full idle", int'(put_full), 0);
    look_all("R1");
    store(50, "R1 first");
  endtask

  task automatic t_fill();
    clear();
    for (int i = 0; i < N; i++) store(100 + 10 * i, "R2 R3");
    look_all("R4");
    store(5, "R5 over count");
    look_all("R5 unchanged");
  endtask

  task automatic t_mem_edge();
    clear();
    look_all("R7");
    store(4000, "R6 large");
    store(100, "R6 overflow");
    store(MEM - BASE - 4000, "R6 exact");
    look_all("R6 unchanged");
  endtask

  task automatic t_clear_race();
    store(7, "R8 pre");
    @(negedge clk);
    clr_req = 1'b1;
    put_req = 1'b1;
    put_len = 16'd9;
    @(negedge clk);
    clr_req = 1'b0;
    put_req = 1'b0;
    model_clear();
    check("R8 ack", int'(put_ack), 0);
    check("R8 full", int'(put_full), 0);
    store(10, "R8 after");
    look_all("R8");
  endtask

  task automatic t_look_race();
    clear();
    store(20, "R9 pre");
    @(negedge clk);
    put_req = 1'b1;
    put_len = 16'd33;
    look_idx = 3'd1;
    @(negedge clk);
    put_req = 1'b0;
    check("R9 ack", int'(put_ack), 1);
    check("R9 old base", int'(look_base), 0);
    check("R9 old len", int'(look_len), 0);
    @(negedge clk);
    check("R9 new base", int'(look_base), BASE + 20);
    check("R9 new len", int'(look_len), 33);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_mem_edge();
    t_clear_race();
    t_look_race();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule